// File: doc/BRIEF.md
# PCI Configuration Header Responder for a Dual-Port Serial Controller

This block answers configuration accesses on the target side for a two-port serial controller that appears as a type-0 device. A requester presents a dword index, four byte-lane enables, a write flag and write data for one cycle. Reads return one registered dword on the following cycle, with the lanes that were not enabled forced to zero. Most of the header is fixed. It holds the identity words, the serial-class code, the command and status words, the interrupt pin and a few vendor-specific constant bytes.

Three pieces of state can be written. The first two are I/O base-address registers, each covering an 8-byte window. They answer the usual all-ones sizing probe with their size mask and always keep their I/O-space flag. The third is the interrupt-line byte. The block drives the decoded base of each I/O window on a port, so a downstream port decoder can use it without going through configuration reads.

Top module: `cfg_hdr_resp`

## Requirements
- R1: A read of dword index 0 (byte offset 0x00) or dword index 11 (byte offset 0x2C) returns 0x32534348. The vendor value 0x4348 is in bits 15:0 and the device value 0x3253 is in bits 31:16.
- R2: A read of dword index 1 returns 0x02000001. That is status 0x0200 in bits 31:16 and command 0x0001 in bits 15:0. Writes to this dword do not change what it reads.
- R3: A read of dword index 2 returns 0x07000210: revision 0x10 in bits 7:0, programming interface 0x02 in bits 15:8, subclass 0x00 in bits 23:16 and base class 0x07 in bits 31:24.
- R4: After reset, both I/O base registers (dword indices 4 and 5) read 0x00000001, and both `io_base` outputs are 0.
- R5: A write to index 4 or 5 is a sizing probe when, after merging the enabled lanes into the old value, the result is all ones. A probe stores 0xFFFFFFF8 ORed with the old bits 1:0.
- R6: Any other write to index 4 or 5 stores the lane-merged value ORed with the old bits 1:0. Lanes whose enable is 0 keep their old byte, and bit 0 stays 1.
- R7: `io_base0` and `io_base1` equal their register with bits 2:0 cleared. They change in the cycle after a write to their own register and at no other time outside reset.
- R8: Dword indices 6, 7 and 8 read zero, including right after a write of any value to them.
- R9: Dword index 15 reads {16'h0000, 8'h01, line}. Lane 0 writes the line byte. The pin byte (bits 15:8) stays 0x01 whatever is written.
- R10: Dword index 13 reads 0. Index 16 reads 0x80000023. Indices 17, 18 and 19 read 0x00000023.
- R11: All other indices below 64 read zero, and writes to them leave every readable value unchanged. Any index of 64 or more (byte offset 0x100 and up) reads zero.
- R12: `acc_rvalid` is high exactly one cycle after each read request and low otherwise. `acc_rdata` then holds the dword with each lane whose request enable was 0 forced to zero. Reads may be issued back to back.
- R13: A synchronous active-high `rst` held for one clock returns the I/O base registers, the line byte and the `io_base` outputs to their initial values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_en | input | 1 | Access request, valid for one cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_dw_addr | input | 10 | Dword index into configuration space |
| acc_be | input | 4 | Byte-lane enables |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, lane-masked |
| acc_rvalid | output | 1 | Read data valid, one cycle after the read request |
| io_base0 | output | 32 | Decoded base of the first 8-byte I/O window |
| io_base1 | output | 32 | Decoded base of the second 8-byte I/O window |

## Verification
Reads of the fixed dwords are issued back to back, so a scoreboard would catch a stuck or shifted read register, and partial-lane reads show that the lane masking is applied. The base registers receive several kinds of write, and each separates a different fault:
- a full all-ones probe, which must produce the size mask;
- plain addresses with bit 1 set, which test that the old low bits are ORed back;
- a single-lane write, which tests the lane merge;
- a probe after bit 1 has been set.

Writes to the command word, the pin byte, the zeroed BARs and unlisted offsets are each followed by a read-back to confirm that nothing moved. A mid-run reset with modified state shows that reset restores every writable field.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

  // dword indices whose behaviour depends on position
  localparam int unsigned IDX_IDENT   = 0;
  localparam int unsigned IDX_CMDSTAT = 1;
  localparam int unsigned IDX_CLASS   = 2;
  localparam int unsigned IDX_IOBAR0  = 4;
  localparam int unsigned IDX_SUBSYS  = 11;
  localparam int unsigned IDX_IRQ     = 15;
  localparam int unsigned IDX_VND0    = 16;
  localparam int unsigned IDX_VND3    = 19;

  // merge enabled lanes of new data over the old dword
  function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  be);
    logic [31:0] r;
    for (int i = 0; i < 4; i++)
      r[i*8 +: 8] = be[i] ? new_v[i*8 +: 8] : old_v[i*8 +: 8];
    return r;
  endfunction

  // read lane mask from byte enables
  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    logic [31:0] r;
    for (int i = 0; i < 4; i++)
      r[i*8 +: 8] = {8{be[i]}};
    return r;
  endfunction

  // size mask for a window of win bytes
  function automatic logic [31:0] size_mask(input int unsigned win);
    return ~(32'(win)) + 32'd1;
  endfunction

  // next value of an I/O BAR after a write
  function automatic logic [31:0] iobar_next(input logic [31:0] old_v,
                                             input logic [31:0] merged,
                                             input int unsigned win);
    logic [31:0] kept;
    kept = {30'd0, old_v[1:0]};
    if (merged == '1) return size_mask(win) | kept;
    return merged | kept;
  endfunction

  // decoded window base
  function automatic logic [31:0] win_base(input logic [31:0] bar,
                                           input int unsigned win);
    return bar & size_mask(win);
  endfunction

endpackage

// File: rtl/cfg_iobar_reg.sv
module cfg_iobar_reg
  import cfg_hdr_pkg::*;
#(
  parameter int unsigned WIN       = 8,
  parameter logic [31:0] RESET_VAL = 32'h0000_0001
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] bar_q,
  output logic [31:0] base,
  output logic        probe_hit
);
  logic [31:0] merged;

  assign merged    = lane_merge(bar_q, wdata, be);
  assign probe_hit = wr_en && (merged == '1);

  always_ff @(posedge clk) begin
    if (rst)        bar_q <= RESET_VAL;
    else if (wr_en) bar_q <= iobar_next(bar_q, merged, WIN);
  end

  assign base = win_base(bar_q, WIN);
endmodule

// File: rtl/cfg_const_rom.sv
module cfg_const_rom
  import cfg_hdr_pkg::*;
#(
  parameter int unsigned IDX_W      = 6,
  parameter logic [31:0] IDENT_WORD = 32'h3253_4348,
  parameter logic [31:0] CMD_STAT   = 32'h0200_0001,
  parameter logic [31:0] CLASS_REV  = 32'h0700_0210,
  parameter logic [7:0]  VND_BYTE   = 8'h23,
  parameter logic [7:0]  VND_TOP    = 8'h80
) (
  input  logic [IDX_W-1:0] idx,
  output logic [31:0]      value
);
  always_comb begin
    value = '0;
    case (int'(idx))
      IDX_IDENT, IDX_SUBSYS: value = IDENT_WORD;
      IDX_CMDSTAT:           value = CMD_STAT;
      IDX_CLASS:             value = CLASS_REV;
      IDX_VND0:              value = {VND_TOP, 16'h0000, VND_BYTE};
      default: begin
        if (int'(idx) > IDX_VND0 && int'(idx) <= IDX_VND3)
          value = {24'h0, VND_BYTE};
      end
    endcase
  end
endmodule

// File: rtl/cfg_hdr_resp.sv
module cfg_hdr_resp
  import cfg_hdr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned CFG_BYTES = 256,
  parameter int unsigned IO_WIN    = 8,
  parameter logic [7:0]  IRQ_PIN   = 8'h01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_dw_addr,
  input  logic [3:0]        acc_be,
  input  logic [31:0]       acc_wdata,
  output logic [31:0]       acc_rdata,
  output logic              acc_rvalid,
  output logic [31:0]       io_base0,
  output logic [31:0]       io_base1
);
  localparam int unsigned N_DW    = CFG_BYTES / 4;
  localparam int unsigned IDX_W   = $clog2(N_DW);
  localparam int unsigned N_IOBAR = 2;

  logic             rd_req, wr_req, in_range;
  logic [IDX_W-1:0] idx;
  logic [31:0]      rom_val, rd_word;
  logic [7:0]       irq_line;
  logic [31:0]      bar_q [N_IOBAR];
  logic [31:0]      base  [N_IOBAR];
  logic [N_IOBAR-1:0] bar_wr, bar_probe;

  // named events for the checker
  logic        wr_bar0, wr_bar1, wr_irq;
  logic [31:0] bar0_q, bar1_q;

  assign rd_req   = acc_en && !acc_wr;
  assign wr_req   = acc_en &&  acc_wr;
  assign in_range = acc_dw_addr < ADDR_W'(N_DW);
  assign idx      = acc_dw_addr[IDX_W-1:0];
  assign wr_irq   = wr_req && in_range && (int'(idx) == IDX_IRQ) && acc_be[0];

  genvar g;
  generate
    for (g = 0; g < N_IOBAR; g++) begin : g_iobar
      assign bar_wr[g] = wr_req && in_range && (int'(idx) == IDX_IOBAR0 + g);
      cfg_iobar_reg #(.WIN(IO_WIN), .RESET_VAL(32'h0000_0001)) u_bar (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (bar_wr[g]),
        .be        (acc_be),
        .wdata     (acc_wdata),
        .bar_q     (bar_q[g]),
        .base      (base[g]),
        .probe_hit (bar_probe[g])
      );
    end
  endgenerate

  assign wr_bar0  = bar_wr[0];
  assign wr_bar1  = bar_wr[1];
  assign bar0_q   = bar_q[0];
  assign bar1_q   = bar_q[1];
  assign io_base0 = base[0];
  assign io_base1 = base[1];

  cfg_const_rom #(.IDX_W(IDX_W)) u_rom (
    .idx   (idx),
    .value (rom_val)
  );

  always_ff @(posedge clk) begin
    if (rst)         irq_line <= 8'h00;
    else if (wr_irq) irq_line <= acc_wdata[7:0];
  end

  always_comb begin
    rd_word = '0;
    if (in_range) begin
      if (int'(idx) == IDX_IOBAR0)          rd_word = bar_q[0];
      else if (int'(idx) == IDX_IOBAR0 + 1) rd_word = bar_q[1];
      else if (int'(idx) == IDX_IRQ)        rd_word = {16'h0000, IRQ_PIN, irq_line};
      else                                  rd_word = rom_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_rvalid <= 1'b0;
      acc_rdata  <= '0;
    end else begin
      acc_rvalid <= rd_req;
      if (rd_req) acc_rdata <= rd_word & lane_mask(acc_be);
    end
  end

  logic unused_probe;
  assign unused_probe = ^bar_probe;
endmodule

// File: rtl/cfg_hdr_resp_chk.sv
module cfg_hdr_resp_chk (
  input logic        clk,
  input logic        rst,
  input logic        rd_req,
  input logic        in_range,
  input logic [5:0]  idx,
  input logic [3:0]  acc_be,
  input logic [31:0] acc_wdata,
  input logic [31:0] acc_rdata,
  input logic        acc_rvalid,
  input logic        wr_bar0,
  input logic        wr_bar1,
  input logic [31:0] bar0_q,
  input logic [31:0] bar1_q,
  input logic [31:0] io_base0,
  input logic [31:0] io_base1
);
  assert_rvalid_follows_R12: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> acc_rvalid);

  assert_no_spurious_rvalid_R12: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !acc_rvalid);

  assert_io_flag_kept_R6: assert property (@(posedge clk) disable iff (rst)
    bar0_q[0] && bar1_q[0]);

  assert_probe_mask_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_bar0 && acc_be == 4'hF && acc_wdata == 32'hFFFF_FFFF)
      |=> (bar0_q[31:3] == {29{1'b1}}));

  assert_base0_stable_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_bar0 |=> $stable(io_base0));

  assert_base1_stable_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_bar1 |=> $stable(io_base1));

  assert_cmd_fixed_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_req && in_range && idx == 6'd1 && acc_be == 4'hF)
      |=> (acc_rdata == 32'h0200_0001));

  assert_oor_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !in_range) |=> (acc_rdata == 32'h0));
endmodule

bind cfg_hdr_resp cfg_hdr_resp_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_req     (rd_req),
  .in_range   (in_range),
  .idx        (idx),
  .acc_be     (acc_be),
  .acc_wdata  (acc_wdata),
  .acc_rdata  (acc_rdata),
  .acc_rvalid (acc_rvalid),
  .wr_bar0    (wr_bar0),
  .wr_bar1    (wr_bar1),
  .bar0_q     (bar0_q),
  .bar1_q     (bar1_q),
  .io_base0   (io_base0),
  .io_base1   (io_base1)
);

// File: tb/cfg_hdr_resp_tb.sv
`timescale 1ns/1ps
module cfg_hdr_resp_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_en = 1'b0, acc_wr = 1'b0;
  logic [9:0]  acc_dw_addr = '0;
  logic [3:0]  acc_be = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata, io_base0, io_base1;
  logic        acc_rvalid;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  cfg_hdr_resp u_dut (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_dw_addr(acc_dw_addr), .acc_be(acc_be), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .acc_rvalid(acc_rvalid),
    .io_base0(io_base0), .io_base1(io_base1)
  );

  function automatic logic [31:0] keep_lanes(input logic [31:0] v, input logic [3:0] be);
    return {be[3] ? v[31:24] : 8'h0, be[2] ? v[23:16] : 8'h0,
            be[1] ? v[15:8]  : 8'h0, be[0] ? v[7:0]   : 8'h0};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one access per cycle, reads push expectations
  task automatic rd(input int a, input logic [3:0] be, input logic [31:0] exp, input string tag);
    @(negedge clk);
    acc_en = 1; acc_wr = 0; acc_dw_addr = 10'(a); acc_be = be; acc_wdata = '0;
    exp_q.push_back(keep_lanes(exp, be));
    tag_q.push_back(tag);
    @(posedge clk); #1 acc_en = 0;
  endtask

  task automatic wr(input int a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    acc_en = 1; acc_wr = 1; acc_dw_addr = 10'(a); acc_be = be; acc_wdata = d;
    @(posedge clk); #1 acc_en = 0; acc_wr = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: compare read results against the queue
  always @(negedge clk) begin
    if (!rst && acc_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R12 spurious rvalid actual=%h expected=none", acc_rdata);
      end else begin
        check(tag_q.pop_front(), acc_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12 rvalid in reset", {31'd0, acc_rvalid}, 32'd0);
    rst = 0;
    @(negedge clk);
    check("R4 base0 reset", io_base0, 32'h0);
    check("R4 base1 reset", io_base1, 32'h0);

    // fixed dwords, back to back
    rd(0,  4'hF, 32'h3253_4348, "R1 ident");
    rd(11, 4'hF, 32'h3253_4348, "R1 subsystem");
    rd(1,  4'hF, 32'h0200_0001, "R2 cmd/status");
    rd(2,  4'hF, 32'h0700_0210, "R3 class/rev");
    rd(4,  4'hF, 32'h0000_0001, "R4 bar0 reset");
    rd(5,  4'hF, 32'h0000_0001, "R4 bar1 reset");
    rd(13, 4'hF, 32'h0,         "R10 cap ptr");
    rd(15, 4'hF, 32'h0000_0100, "R9 irq reset");
    rd(16, 4'hF, 32'h8000_0023, "R10 vendor 0x40");
    rd(17, 4'hF, 32'h0000_0023, "R10 vendor 0x44");
    rd(18, 4'hF, 32'h0000_0023, "R10 vendor 0x48");
    rd(19, 4'hF, 32'h0000_0023, "R10 vendor 0x4C");
    rd(0,  4'b0010, 32'h3253_4348, "R12 lane mask 1");
    rd(2,  4'b1000, 32'h0700_0210, "R12 lane mask 3");

    // command ignores writes
    wr(1, 4'hF, 32'hFFFF_FFFF);
    rd(1, 4'hF, 32'h0200_0001, "R2 cmd after write");

    // BAR0 probe then address
    wr(4, 4'hF, 32'hFFFF_FFFF);
    rd(4, 4'hF, 32'hFFFF_FFF9, "R5 bar0 probe");
    @(negedge clk);
    check("R7 base0 after probe", io_base0, 32'hFFFF_FFF8);
    check("R7 base1 untouched", io_base1, 32'h0);
    wr(4, 4'hF, 32'h0000_C150);
    rd(4, 4'hF, 32'h0000_C151, "R6 bar0 addr");
    @(negedge clk);
    check("R7 base0 addr", io_base0, 32'h0000_C150);

    // BAR1: bit1 written, lane merge, then probe keeps bit1
    wr(5, 4'hF, 32'h0000_C15A);
    rd(5, 4'hF, 32'h0000_C15B, "R6 bar1 low bits or");
    @(negedge clk);
    check("R7 base1 addr", io_base1, 32'h0000_C158);
    wr(5, 4'b0001, 32'h1234_56FF);
    rd(5, 4'hF, 32'h0000_C1FF, "R6 bar1 lane merge");
    wr(5, 4'hF, 32'hFFFF_FFFF);
    rd(5, 4'hF, 32'hFFFF_FFFB, "R5 bar1 probe keeps bits");
    @(negedge clk);
    check("R7 base1 probe", io_base1, 32'hFFFF_FFF8);
    check("R7 base0 held", io_base0, 32'h0000_C150);

    // zeroed BARs
    wr(6, 4'hF, 32'h1234_5678);
    rd(6, 4'hF, 32'h0, "R8 bar2 zero");
    wr(8, 4'hF, 32'hFFFF_FFFF);
    rd(8, 4'hF, 32'h0, "R8 bar4 zero");

    // interrupt line and pin
    wr(15, 4'b0011, 32'h0000_AA0A);
    rd(15, 4'hF, 32'h0000_010A, "R9 line written pin kept");
    wr(15, 4'b0010, 32'h0000_FF00);
    rd(15, 4'hF, 32'h0000_010A, "R9 pin write ignored");

    // unlisted and out of range
    wr(24, 4'hF, 32'hFFFF_FFFF);
    rd(24, 4'hF, 32'h0, "R11 unlisted zero");
    rd(4,  4'hF, 32'h0000_C151, "R11 bar0 untouched");
    rd(64, 4'hF, 32'h0, "R11 offset 0x100");
    rd(1023, 4'hF, 32'h0, "R11 top index");
    idle(2);

    // reset restores writable state
    wr(15, 4'b0001, 32'h0000_0055);
    idle(2);
    @(negedge clk) rst = 1;
    @(negedge clk) rst = 0;
    check("R13 base0 after reset", io_base0, 32'h0);
    check("R13 base1 after reset", io_base1, 32'h0);
    rd(15, 4'hF, 32'h0000_0100, "R13 line after reset");
    rd(4,  4'hF, 32'h0000_0001, "R13 bar0 after reset");
    rd(5,  4'hF, 32'h0000_0001, "R13 bar1 after reset");
    idle(3);

    check("R12 all reads answered", 32'(exp_q.size()), 32'd0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule